// File: doc/BRIEF.md
# Sub-word Lane Access Unit

This block gives a datapath that only moves whole 32-bit words a way to read and write single bytes and 16-bit halves. A load takes one lane out of a source word and returns it right-aligned, either sign-extended or zero-extended. A store puts a byte or half into one lane of a destination word and leaves every other lane as it was. The lane is not encoded in the instruction. It comes from the two low bits of the pointer that is paired with the operand. An operand with no pointer, a plain register, always uses lane zero.

Each accepted operation also reports how far the paired pointer should advance: one for bytes, two for halves, zero otherwise. A half access that would straddle the word boundary raises a trap instead. The unit also provides a plain move and a store-high operation. Used after a half store, store-high builds a full 32-bit constant from two 16-bit immediates. Refilling the data word when the pointer crosses a word boundary is done by the surrounding logic.

Top module: `subword_lane_unit`

## Requirements
- R1: The lane offset equals `ptr_lsb` when `ptr_linked` is 1 and is 0 when `ptr_linked` is 0.
- R2: Byte loads (`op` 1 signed, 2 unsigned) return source byte number `offset` (bits 8*offset+7..8*offset), sign- or zero-extended to 32 bits, with increment 1.
- R3: Half loads (`op` 3 signed, 4 unsigned) return the 16 bits starting at byte `offset`, sign- or zero-extended, with increment 2.
- R4: A half load or half store at offset 3 sets `res_trap`, forces `res_incr` to 0 and `res_word` to 0. Byte operations never trap.
- R5: A byte store (`op` 5) replaces only byte `offset` of `dst_val` with the low byte of `imm` (`use_imm`=1) or of `src_val` (`use_imm`=0), with increment 1.
- R6: A half store (`op` 6) to a linked destination replaces only the 16 bits at byte `offset`, with increment 2. To a plain destination it writes the 16-bit value sign-extended over the whole word.
- R7: Store-high (`op` 7) replaces bits 31..16 of `dst_val` with the low 16 bits of `imm` or `src_val` and keeps bits 15..0. It ignores the pointer, never traps and has increment 0.
- R8: Move (`op` 0) returns `src_val`, or `imm` sign-extended to 32 bits when `use_imm` is 1, with increment 0.
- R9: `res_valid` is 1 exactly in the cycle after `issue` was 1. Without `issue`, `res_word`, `res_incr` and `res_trap` hold their values.
- R10: During reset `res_valid`, `res_word`, `res_incr` and `res_trap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation present this cycle |
| op | input | 3 | Operation select (0 move, 1-4 loads, 5-7 stores) |
| use_imm | input | 1 | Take value from `imm` instead of `src_val` |
| ptr_linked | input | 1 | Operand has a paired pointer |
| ptr_lsb | input | 2 | Low bits of the paired pointer |
| src_val | input | 32 | Source register word |
| dst_val | input | 32 | Current destination word (stores) |
| imm | input | 16 | Immediate field |
| res_valid | output | 1 | Result strobe |
| res_word | output | 32 | Result word |
| res_incr | output | 2 | Pointer advance to apply |
| res_trap | output | 1 | Illegal half offset |

## Verification
The bench builds the unit with its default 32-bit word, so there are four byte lanes and offset 3 is the only illegal slot for a half. With that width every lane can be reached for byte loads and stores. All three legal half slots can be reached, and so can the one illegal slot. Each lane uses data whose sign bit is set in some lanes and clear in others, so a wrong extension or a wrong lane shows up in the result.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  typedef enum logic [2:0] {
    OP_MOVE = 3'd0,
    OP_LDSB = 3'd1,
    OP_LDZB = 3'd2,
    OP_LDSH = 3'd3,
    OP_LDZH = 3'd4,
    OP_STB  = 3'd5,
    OP_STH  = 3'd6,
    OP_STHI = 3'd7
  } lane_op_e;
endpackage

// File: rtl/lane_ctrl.sv
`timescale 1ns/1ps
// Decodes the operation into lane offset, pointer advance and trap.
module lane_ctrl #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = $clog2(DATA_W/8)
) (
  input  lane_pkg::lane_op_e op,
  input  logic               linked,
  input  logic [OFS_W-1:0]   ptr_lsb,
  output logic [OFS_W-1:0]   ofs,
  output logic [1:0]         incr,
  output logic               trap
);
  import lane_pkg::*;
  localparam int LANES = DATA_W/8;
  localparam logic [OFS_W-1:0] HALF_MAX = OFS_W'(LANES-2);

  logic byte_op, half_op;

  always_comb begin
    ofs     = linked ? ptr_lsb : '0;
    byte_op = (op == OP_LDSB) || (op == OP_LDZB) || (op == OP_STB);
    half_op = (op == OP_LDSH) || (op == OP_LDZH) || (op == OP_STH);
    trap    = half_op && (ofs > HALF_MAX);
    if (trap)         incr = 2'd0;
    else if (byte_op) incr = 2'd1;
    else if (half_op) incr = 2'd2;
    else              incr = 2'd0;
  end
endmodule

// File: rtl/lane_extract.sv
`timescale 1ns/1ps
// Shifts the addressed lane down and extends it.
module lane_extract #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = $clog2(DATA_W/8)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              half,
  input  logic              sext,
  output logic [DATA_W-1:0] lane_out
);
  logic [OFS_W+2:0]  sh;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    sh      = {ofs, 3'b000};
    shifted = word >> sh;
    if (half)
      lane_out = {{(DATA_W-16){sext & shifted[15]}}, shifted[15:0]};
    else
      lane_out = {{(DATA_W-8){sext & shifted[7]}}, shifted[7:0]};
  end
endmodule

// File: rtl/lane_insert.sv
`timescale 1ns/1ps
// Merges a byte or half into one lane of the destination word.
module lane_insert #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = $clog2(DATA_W/8)
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [15:0]       val,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              half,
  input  logic              high,
  input  logic              plain,
  output logic [DATA_W-1:0] merged
);
  localparam int TOP_SH = DATA_W - 16;

  logic [OFS_W+2:0]  sh;
  logic [DATA_W-1:0] mask, data;

  always_comb begin
    sh = {ofs, 3'b000};
    if (high) begin
      mask = {{16{1'b1}}, {(DATA_W-16){1'b0}}};
      data = {val, {(DATA_W-16){1'b0}}};
    end else if (half) begin
      mask = {{(DATA_W-16){1'b0}}, 16'hFFFF} << sh;
      data = {{(DATA_W-16){1'b0}}, val} << sh;
    end else begin
      mask = {{(DATA_W-8){1'b0}}, 8'hFF} << sh;
      data = {{(DATA_W-8){1'b0}}, val[7:0]} << sh;
    end
    if (half && plain && !high)
      merged = {{(DATA_W-16){val[15]}}, val};
    else
      merged = (dst & ~mask) | data;
  end

  // high half lands at TOP_SH; keep parameter referenced for narrow builds
  initial assert (TOP_SH >= 16);
endmodule

// File: rtl/subword_lane_unit.sv
`timescale 1ns/1ps
module subword_lane_unit #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = $clog2(DATA_W/8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic              ptr_linked,
  input  logic [OFS_W-1:0]  ptr_lsb,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [15:0]       imm,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_word,
  output logic [1:0]        res_incr,
  output logic              res_trap
);
  import lane_pkg::*;

  lane_op_e          op_e;
  logic [OFS_W-1:0]  ofs;
  logic [1:0]        incr_d;
  logic              trap_d;
  logic [DATA_W-1:0] load_word, store_word, word_d;
  logic [15:0]       st_val;
  logic              is_half_ld, is_signed, is_half_st, is_high;
  logic              rst_meta, rst_sync;

  // reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    op_e       = lane_op_e'(op);
    is_half_ld = (op_e == OP_LDSH) || (op_e == OP_LDZH);
    is_signed  = (op_e == OP_LDSB) || (op_e == OP_LDSH);
    is_half_st = (op_e == OP_STH);
    is_high    = (op_e == OP_STHI);
    st_val     = use_imm ? imm : src_val[15:0];
  end

  lane_ctrl #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ctrl (
    .op(op_e), .linked(ptr_linked), .ptr_lsb(ptr_lsb),
    .ofs(ofs), .incr(incr_d), .trap(trap_d)
  );

  lane_extract #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_extract (
    .word(src_val), .ofs(ofs), .half(is_half_ld), .sext(is_signed),
    .lane_out(load_word)
  );

  lane_insert #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_insert (
    .dst(dst_val), .val(st_val), .ofs(ofs), .half(is_half_st),
    .high(is_high), .plain(!ptr_linked), .merged(store_word)
  );

  // next-state selection
  always_comb begin
    unique case (op_e)
      OP_MOVE: word_d = use_imm ? {{(DATA_W-16){imm[15]}}, imm} : src_val;
      OP_LDSB, OP_LDZB, OP_LDSH, OP_LDZH: word_d = load_word;
      default: word_d = store_word;
    endcase
    if (trap_d) word_d = '0;
  end

  // result registers, enabled by issue
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_incr  <= 2'd0;
      res_trap  <= 1'b0;
    end else begin
      res_valid <= issue;
      if (issue) begin
        res_word <= word_d;
        res_incr <= incr_d;
        res_trap <= trap_d;
      end
    end
  end

  a_r4_trap_no_advance: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    res_trap |-> (res_incr == 2'd0 && res_word == '0));

  a_r4_byte_never_traps: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    issue && (op == 3'd1 || op == 3'd2 || op == 3'd5) |=> !res_trap && res_incr == 2'd1);

  a_r7_high_ignores_ptr: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    issue && op == 3'd7 |=> !res_trap && res_incr == 2'd0);

  a_r9_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    issue |=> res_valid);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    !issue |=> !res_valid && $stable(res_word) && $stable(res_incr) && $stable(res_trap));

  a_r8_move_no_advance: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    issue && op == 3'd0 |=> res_incr == 2'd0 && !res_trap);
endmodule

// File: tb/subword_lane_unit_bench.sv
`timescale 1ns/1ps
module subword_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue, use_imm, ptr_linked;
  logic [2:0]  op;
  logic [1:0]  ptr_lsb;
  logic [31:0] src_val, dst_val;
  logic [15:0] imm;
  logic        res_valid, res_trap;
  logic [31:0] res_word;
  logic [1:0]  res_incr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  subword_lane_unit u_subword_lane_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .use_imm(use_imm),
    .ptr_linked(ptr_linked), .ptr_lsb(ptr_lsb), .src_val(src_val),
    .dst_val(dst_val), .imm(imm), .res_valid(res_valid), .res_word(res_word),
    .res_incr(res_incr), .res_trap(res_trap)
  );

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got valid/trap/incr/word=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [2:0] o, input logic ui,
                        input logic lk, input logic [1:0] pl,
                        input logic [31:0] s, input logic [31:0] d, input logic [15:0] im,
                        input logic [31:0] ew, input logic [1:0] ei, input logic et);
    @(negedge clk);
    op = o; use_imm = ui; ptr_linked = lk; ptr_lsb = pl;
    src_val = s; dst_val = d; imm = im; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    check(tag, {res_valid, res_trap, res_incr, res_word}, {1'b1, et, ei, ew});
  endtask

  task automatic t_reset;
    check("R10 reset state", {res_valid, res_trap, res_incr, res_word}, 36'h0);
  endtask

  task automatic t_byte_load;
    run_op("R2 signed byte ofs1", 3'd1, 0, 1, 2'd1, 32'h12345678, 0, 0, 32'h00000056, 2'd1, 0);
    run_op("R2 signed byte ofs0", 3'd1, 0, 1, 2'd0, 32'h80FF7F01, 0, 0, 32'h00000001, 2'd1, 0);
    run_op("R2 signed byte ofs2", 3'd1, 0, 1, 2'd2, 32'h80FF7F01, 0, 0, 32'hFFFFFFFF, 2'd1, 0);
    run_op("R2 unsigned byte ofs2", 3'd2, 0, 1, 2'd2, 32'h80FF7F01, 0, 0, 32'h000000FF, 2'd1, 0);
    run_op("R2 unsigned byte ofs3", 3'd2, 0, 1, 2'd3, 32'h80FF7F01, 0, 0, 32'h00000080, 2'd1, 0);
    run_op("R4 signed byte ofs3 no trap", 3'd1, 0, 1, 2'd3, 32'h80FF7F01, 0, 0, 32'hFFFFFF80, 2'd1, 0);
    run_op("R1 plain operand uses lane 0", 3'd2, 0, 0, 2'd3, 32'h80FF7F01, 0, 0, 32'h00000001, 2'd1, 0);
  endtask

  task automatic t_half_load;
    run_op("R3 signed half ofs0", 3'd3, 0, 1, 2'd0, 32'h80FF7F01, 0, 0, 32'h00007F01, 2'd2, 0);
    run_op("R3 signed half ofs1", 3'd3, 0, 1, 2'd1, 32'h80FF7F01, 0, 0, 32'hFFFFFF7F, 2'd2, 0);
    run_op("R3 unsigned half ofs2", 3'd4, 0, 1, 2'd2, 32'h80FF7F01, 0, 0, 32'h000080FF, 2'd2, 0);
    run_op("R3 signed half ofs2", 3'd3, 0, 1, 2'd2, 32'h80FF7F01, 0, 0, 32'hFFFF80FF, 2'd2, 0);
  endtask

  task automatic t_trap;
    run_op("R4 half load ofs3 traps", 3'd3, 0, 1, 2'd3, 32'h80FF7F01, 0, 0, 32'h0, 2'd0, 1);
    run_op("R4 half store ofs3 traps", 3'd6, 1, 1, 2'd3, 0, 32'h12345678, 16'h4567, 32'h0, 2'd0, 1);
    run_op("R1 R4 plain half ofs ignored", 3'd4, 0, 0, 2'd3, 32'h80FF7F01, 0, 0, 32'h00007F01, 2'd2, 0);
  endtask

  task automatic t_byte_store;
    run_op("R5 byte store reg ofs1", 3'd5, 0, 1, 2'd1, 32'h9ABCDEF0, 32'h12345678, 16'hAAAA, 32'h1234F078, 2'd1, 0);
    run_op("R5 byte store imm ofs0", 3'd5, 1, 1, 2'd0, 32'h55555555, 32'h89ABCDEF, 16'h0123, 32'h89ABCD23, 2'd1, 0);
    run_op("R5 byte store imm ofs3", 3'd5, 1, 1, 2'd3, 0, 32'h89ABCDEF, 16'h00C3, 32'hC3ABCDEF, 2'd1, 0);
  endtask

  task automatic t_half_store;
    run_op("R6 half store reg ofs2", 3'd6, 0, 1, 2'd2, 32'h9ABCDEF0, 32'h1234F078, 0, 32'hDEF0F078, 2'd2, 0);
    run_op("R6 half store imm ofs1", 3'd6, 1, 1, 2'd1, 0, 32'h89ABCD23, 16'h4567, 32'h89456723, 2'd2, 0);
    run_op("R6 plain half neg sext", 3'd6, 1, 0, 2'd1, 0, 32'h11111111, 16'h89AB, 32'hFFFF89AB, 2'd2, 0);
    run_op("R6 plain half pos sext", 3'd6, 1, 0, 2'd0, 0, 32'h11111111, 16'h5678, 32'h00005678, 2'd2, 0);
  endtask

  task automatic t_store_high;
    run_op("R7 store high imm ofs3", 3'd7, 1, 1, 2'd3, 0, 32'hFFFF89AB, 16'hCDEF, 32'hCDEF89AB, 2'd0, 0);
    run_op("R7 store high reg", 3'd7, 0, 0, 2'd0, 32'hAAAA1234, 32'h00005678, 16'hFFFF, 32'h12345678, 2'd0, 0);
  endtask

  task automatic t_move;
    run_op("R8 move reg", 3'd0, 0, 1, 2'd2, 32'hDEADBEEF, 32'h0, 16'h1111, 32'hDEADBEEF, 2'd0, 0);
    run_op("R8 move imm neg", 3'd0, 1, 0, 2'd0, 32'h0, 32'h0, 16'h8001, 32'hFFFF8001, 2'd0, 0);
    run_op("R8 move imm pos", 3'd0, 1, 1, 2'd3, 32'hFFFFFFFF, 32'h0, 16'h7FFF, 32'h00007FFF, 2'd0, 0);
  endtask

  task automatic t_hold;
    run_op("R9 issue before idle", 3'd2, 0, 1, 2'd1, 32'h0000AB00, 0, 0, 32'h000000AB, 2'd1, 0);
    op = 3'd3; ptr_lsb = 2'd3; src_val = 32'hFFFFFFFF;
    @(negedge clk);
    check("R9 idle holds result", {res_valid, res_trap, res_incr, res_word},
          {1'b0, 1'b0, 2'd1, 32'h000000AB});
  endtask

  initial begin
    rst_n = 1'b0; issue = 1'b0; op = 3'd0; use_imm = 1'b0; ptr_linked = 1'b0;
    ptr_lsb = 2'd0; src_val = '0; dst_val = '0; imm = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_byte_load();
    t_half_load();
    t_trap();
    t_byte_store();
    t_half_store();
    t_store_high();
    t_move();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule